// File: doc/BRIEF.md
# Variable-Width Integer ALU With Condition Flags

This block executes one two-operand integer operation per accepted request. The destination register value `in_dst` is also the first source. The second source is `in_src`, and a separate count register `in_cnt` supplies the shift amount. Each request picks an operand width of one, two or four bytes. Arithmetic, the flags and the shift limits are all evaluated at that width. The writeback value is the full 32-bit destination: the bytes above the selected width carry their old contents.

Every flag-updating operation loads four condition flags: sign, zero, carry and parity. The flags are held in the block and are visible on plain output pins. A combinational branch evaluator reads them and answers whether a selected condition holds.

Requests enter through a valid/ready handshake, and results leave through a second one. One output register sits between the two. A request is accepted when `in_valid` and `in_ready` are both high on a clock edge, and its result is offered from the next cycle on. While `out_valid` is high and `out_ready` is low, the offered result must not change, and `in_ready` drops so that no new request can overwrite it. The flags change in the cycle after the accepting edge, whether or not the result has been taken yet.

Top module: `vwalu_top`

## Requirements
- R1: `in_width` codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. `in_op` codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 shift left, 8 logical shift right, 9 arithmetic shift right and 10 compare. Each result is computed modulo 2^(8 x bytes). Codes 11 to 15 write nothing, set `out_wdata` to `in_dst` and keep the flags.
- R2: Bits of `out_wdata` above the selected width equal the matching bits of `in_dst`.
- R3: Sign is the top bit of the result at the selected width. Zero is set when the result at that width is all zeros. Parity is 1 when result bits 7..0 hold an even number of ones.
- R4: Add sets carry to the carry-out at the selected width. Subtract and compare set carry when the first operand, taken as unsigned at that width, is below the second. AND, OR and XOR clear carry.
- R5: Increment and decrement update sign, zero and parity and leave carry at its previous value.
- R6: Compare updates all four flags, drives `out_wen` low and returns `in_dst` unchanged on `out_wdata`.
- R7: Shift count is `in_cnt[7:0]`, and the other count bits are ignored. A count of 0 returns the operand and leaves all flags unchanged. Otherwise carry is the last bit shifted out: 0 for shifts past the width, or the sign bit for the arithmetic right shift. A count at or above the width gives zero, or all sign bits for the arithmetic right shift.
- R8: `br_taken` is combinational from the current flags. `br_cond` 0 = zero set, 1 = zero clear, 2 = carry set (unsigned below), 3 = carry clear (unsigned above or equal).
- R9: `in_ready` = !`out_valid` or `out_ready`. A result appears one cycle after acceptance and stays stable while stalled. Flags update in the cycle after acceptance.
- R10: After reset `out_valid` is 0 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 4 | Operation code |
| in_width | input | 2 | Operand width code |
| in_dst | input | 32 | Destination / first source register value |
| in_src | input | 32 | Second source value |
| in_cnt | input | 32 | Count register (low 8 bits used) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_wdata | output | 32 | Merged writeback value |
| out_wen | output | 1 | Destination is to be written |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_p | output | 1 | Parity flag |
| br_cond | input | 2 | Branch condition select |
| br_taken | output | 1 | Selected condition holds |

## Verification
Only two pieces of state survive a cycle here: the flag register and the output register. A fault in either shows at the ports one cycle after the accepting edge. A wrong flag is seen directly on the flag pins and through `br_taken`. A corrupted byte lane or a lost stall is seen on `out_wdata` and `out_valid`. A flag that is wrongly kept, for example carry across increment or everything across a zero-count shift, hides until the flag value before the operation differs from the one after. For that reason the stimulus sets each flag both ways before those operations. Running a reference model in lockstep on every clock catches a divergence in the cycle it appears.

// File: rtl/vwalu_pkg.sv
package vwalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
    OP_XOR = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_SHL = 4'd7,
    OP_SHR = 4'd8, OP_SAR = 4'd9, OP_CMP = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    BR_EQ = 2'd0, BR_NE = 2'd1, BR_BELOW = 2'd2, BR_AE = 2'd3
  } cond_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic p;
  } flags_t;

  // Bit idx of v, without a variable part-select.
  function automatic logic bit_of(input logic [63:0] v, input int idx);
    logic [63:0] t;
    t = v >> idx;
    return t[0];
  endfunction
endpackage

// File: rtl/vwalu_arith.sv
module vwalu_arith
  import vwalu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NBW = $clog2(DW) + 1
) (
  input  op_e             op,
  input  logic [NBW-1:0]  nb,
  input  logic [DW-1:0]   mask,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            c_in,
  output logic [DW-1:0]   res,
  output logic            c_out
);
  logic [DW-1:0] am, bm, opnd;
  logic [DW:0]   sum, top;
  logic          is_minus;

  always_comb begin
    am       = a & mask;
    opnd     = (op == OP_INC || op == OP_DEC) ? DW'(1) : b;
    bm       = opnd & mask;
    is_minus = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
    sum      = is_minus ? ({1'b0, am} - {1'b0, bm}) : ({1'b0, am} + {1'b0, bm});
    top      = sum >> nb;
    res      = am;
    c_out    = c_in;
    case (op)
      OP_ADD:         begin res = sum[DW-1:0] & mask; c_out = top[0];  end
      OP_SUB, OP_CMP: begin res = sum[DW-1:0] & mask; c_out = am < bm; end
      OP_INC, OP_DEC: res = sum[DW-1:0] & mask;
      OP_AND:         begin res = am & bm; c_out = 1'b0; end
      OP_OR:          begin res = am | bm; c_out = 1'b0; end
      OP_XOR:         begin res = am ^ bm; c_out = 1'b0; end
      default:        ;
    endcase
  end
endmodule

// File: rtl/vwalu_shift.sv
module vwalu_shift
  import vwalu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int CW  = 8,
  parameter int NBW = $clog2(DW) + 1
) (
  input  op_e             op,
  input  logic [NBW-1:0]  nb,
  input  logic [DW-1:0]   mask,
  input  logic [DW-1:0]   a,
  input  logic [CW-1:0]   cnt,
  input  logic            c_in,
  output logic [DW-1:0]   res,
  output logic            c_out
);
  logic [DW-1:0] am, sx;
  logic          sign;
  int            cn, nbi;

  always_comb begin
    am    = a & mask;
    cn    = int'(cnt);
    nbi   = int'(nb);
    sign  = bit_of(64'(am), nbi - 1);
    sx    = am | (sign ? ~mask : '0);
    res   = am;
    c_out = c_in;
    case (op)
      OP_SHL: begin
        res = (cn >= nbi) ? '0 : ((am << cn) & mask);
        if (cn != 0) c_out = (cn <= nbi) ? bit_of(64'(am), nbi - cn) : 1'b0;
      end
      OP_SHR: begin
        res = (cn >= nbi) ? '0 : (am >> cn);
        if (cn != 0) c_out = (cn <= nbi) ? bit_of(64'(am), cn - 1) : 1'b0;
      end
      OP_SAR: begin
        res = (cn >= nbi) ? (sign ? mask : '0) : (DW'($signed(sx) >>> cn) & mask);
        if (cn != 0) c_out = (cn <= nbi) ? bit_of(64'(am), cn - 1) : sign;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vwalu_branch.sv
module vwalu_branch
  import vwalu_pkg::*;
(
  input  logic [1:0] cond,
  input  logic       z,
  input  logic       c,
  output logic       taken
);
  always_comb begin
    case (cond_e'(cond))
      BR_EQ:    taken = z;
      BR_NE:    taken = !z;
      BR_BELOW: taken = c;
      default:  taken = !c;
    endcase
  end
endmodule

// File: rtl/vwalu_top.sv
module vwalu_top
  import vwalu_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [1:0]    in_width,
  input  logic [DW-1:0] in_dst,
  input  logic [DW-1:0] in_src,
  input  logic [DW-1:0] in_cnt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_wdata,
  output logic          out_wen,
  output logic          flag_s,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_p,
  input  logic [1:0]    br_cond,
  output logic          br_taken
);
  localparam int NBW   = $clog2(DW) + 1;
  localparam int NLANE = DW / 8;

  op_e            op;
  logic [NBW-1:0] nb, nbytes;
  logic [DW-1:0]  mask, ar_res, sh_res, res, merged, nxt_wdata;
  logic           ar_c, sh_c, c_new, is_shift, known, upd, wen, accept;
  logic           cnt_unused;
  flags_t         flg, nf;

  assign op         = op_e'(in_op);
  assign cnt_unused = ^in_cnt[DW-1:CW];
  assign nb         = (in_width == 2'd0) ? NBW'(8) : (in_width == 2'd1) ? NBW'(16) : NBW'(DW);
  assign nbytes     = nb >> 3;
  assign mask       = (int'(nb) >= DW) ? '1 : ((DW'(1) << nb) - DW'(1));
  assign in_ready   = !out_valid || out_ready;
  assign accept     = in_valid && in_ready;

  vwalu_arith #(.DW(DW), .NBW(NBW)) u_arith (
    .op(op), .nb(nb), .mask(mask), .a(in_dst), .b(in_src),
    .c_in(flg.c), .res(ar_res), .c_out(ar_c)
  );

  vwalu_shift #(.DW(DW), .CW(CW), .NBW(NBW)) u_shift (
    .op(op), .nb(nb), .mask(mask), .a(in_dst), .cnt(in_cnt[CW-1:0]),
    .c_in(flg.c), .res(sh_res), .c_out(sh_c)
  );

  // Byte-lane merge: lanes at or above the operation width keep the old value.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign merged[8*g +: 8] = (g < int'(nbytes)) ? res[8*g +: 8] : in_dst[8*g +: 8];
  end

  always_comb begin
    is_shift  = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
    known     = (in_op <= 4'd10);
    res       = is_shift ? sh_res : ar_res;
    c_new     = is_shift ? sh_c : ar_c;
    upd       = known && !(is_shift && (in_cnt[CW-1:0] == '0));
    wen       = known && (op != OP_CMP);
    nxt_wdata = wen ? merged : in_dst;
    nf.s      = bit_of(64'(res), int'(nb) - 1);
    nf.z      = (res == '0);
    nf.c      = c_new;
    nf.p      = ~^res[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wdata <= '0;
      out_wen   <= 1'b0;
      flg       <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_wdata <= nxt_wdata;
        out_wen   <= wen;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && upd) flg <= nf;
    end
  end

  assign flag_s = flg.s;
  assign flag_z = flg.z;
  assign flag_c = flg.c;
  assign flag_p = flg.p;

  vwalu_branch u_branch (.cond(br_cond), .z(flg.z), .c(flg.c), .taken(br_taken));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_wdata) && $stable(out_wen));

  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_width == 2'd0 |=> out_wdata[DW-1:8] == $past(in_dst[DW-1:8]));

  assert_incdec_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 4'd5 || in_op == 4'd6) |=> flag_c == $past(flag_c));

  assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd10 |=> !out_wen && out_wdata == $past(in_dst));

  assert_parity_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd0 |=> flag_p == ~^out_wdata[7:0]);

  assert_shift_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op >= 4'd7 && in_op <= 4'd9 && in_cnt[CW-1:0] == '0
    |=> $stable({flag_s, flag_z, flag_c, flag_p}));
endmodule

// File: tb/vwalu_top_tb.sv
`timescale 1ns/100ps
module vwalu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_width = '0;
  logic [31:0] in_dst = '0, in_src = '0, in_cnt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_wdata;
  logic        out_wen;
  logic        flag_s, flag_z, flag_c, flag_p;
  logic [1:0]  br_cond = '0;
  logic        br_taken;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  bit bp = 0;

  // reference state
  bit     m_ov = 0, m_wen = 0, m_s = 0, m_z = 0, m_c = 0, m_p = 0, m_rdy;
  longint m_wd = 0, m_dst = 0;
  string  m_tag = "R1";

  always #2.5 clk = ~clk;

  vwalu_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_width(in_width), .in_dst(in_dst), .in_src(in_src),
    .in_cnt(in_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_wdata(out_wdata), .out_wen(out_wen), .flag_s(flag_s), .flag_z(flag_z),
    .flag_c(flag_c), .flag_p(flag_p), .br_cond(br_cond), .br_taken(br_taken)
  );

  function automatic void chk(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void ref_op(input int op, input int w, input longint dst, input longint src,
                                 input longint cnt, output longint wd, output bit wen,
                                 output bit upd, inout bit s, inout bit z, inout bit c, inout bit p);
    int     n;
    longint lim, a, b, r, sv, cc;
    n   = (w == 0) ? 8 : (w == 1) ? 16 : 32;
    lim = longint'(1) << n;
    a   = dst % lim;
    b   = src % lim;
    r   = a;
    upd = 1;
    wen = (op <= 9);
    case (op)
      0: begin r = a + b; c = (r >= lim); r = r % lim; end
      1, 10: begin r = a - b; c = (a < b); if (r < 0) r += lim; end
      2: begin r = a & b; c = 0; end
      3: begin r = a | b; c = 0; end
      4: begin r = a ^ b; c = 0; end
      5: r = (a + 1) % lim;
      6: r = (a - 1 + lim) % lim;
      7: if (cnt == 0) upd = 0;
         else begin
           c = (cnt <= n) ? (((a << cnt) >> n) & 1) : 0;
           r = (cnt >= n) ? 0 : ((a << cnt) % lim);
         end
      8: if (cnt == 0) upd = 0;
         else begin
           c = (cnt <= n) ? ((a >> (cnt - 1)) & 1) : 0;
           r = a >> cnt;
         end
      9: if (cnt == 0) upd = 0;
         else begin
           sv = (a >= lim / 2) ? a - lim : a;
           cc = (cnt > 63) ? 63 : cnt;
           c  = (cnt <= n) ? ((sv >>> (cnt - 1)) & 1) : (a >= lim / 2);
           r  = sv >>> cc;
           if (r < 0) r += lim;
         end
      default: upd = 0;
    endcase
    wd = wen ? (dst - a + r) : dst;
    if (upd) begin
      s = (r >> (n - 1)) & 1;
      z = (r == 0);
      p = ($countones(r & 255) % 2) == 0;
    end
  endfunction

  // Lockstep model, compared on every clock.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ov = 0; m_wen = 0; m_wd = 0; m_s = 0; m_z = 0; m_c = 0; m_p = 0;
    end else begin
      bit upd_l;
      bit c_before;
      m_rdy = !m_ov || out_ready;
      if (m_ov && out_ready) m_ov = 0;
      if (in_valid && m_rdy) begin
        c_before = m_c;
        ref_op(int'(in_op), int'(in_width), longint'(in_dst), longint'(in_src),
               longint'(in_cnt[7:0]), m_wd, m_wen, upd_l, m_s, m_z, m_c, m_p);
        m_dst = longint'(in_dst);
        m_ov  = 1;
        if (in_op >= 7 && in_op <= 9) m_tag = "R7";
        else if (in_op == 10) m_tag = "R6";
        else if (in_op == 5 || in_op == 6) m_tag = (c_before != m_c) ? "R5x" : "R5";
        else m_tag = "R1";
      end
    end
    #1;
    if (!rst_n) begin
      chk("R10", "out_valid", out_valid, 0);
      chk("R10", "flags", {flag_s, flag_z, flag_c, flag_p}, 0);
    end else begin
      chk("R9", "in_ready", in_ready, !m_ov || out_ready);
      chk("R9", "out_valid", out_valid, m_ov);
      if (m_ov) begin
        chk(m_tag, "out_wdata", out_wdata, m_wd);
        chk("R2", "upper bytes", out_wdata >> 8, m_wd >> 8);
        chk(m_tag == "R6" ? "R6" : "R1", "out_wen", out_wen, m_wen);
      end
      chk("R3", "flag_s", flag_s, m_s);
      chk("R3", "flag_z", flag_z, m_z);
      chk("R3", "flag_p", flag_p, m_p);
      chk(m_tag == "R5" ? "R5" : "R4", "flag_c", flag_c, m_c);
      case (br_cond)
        2'd0: chk("R8", "br_taken EQ", br_taken, m_z);
        2'd1: chk("R8", "br_taken NE", br_taken, !m_z);
        2'd2: chk("R8", "br_taken BELOW", br_taken, m_c);
        default: chk("R8", "br_taken AE", br_taken, !m_c);
      endcase
    end
  end

  task automatic send(int op, int w, logic [31:0] d, logic [31:0] s, logic [31:0] c);
    in_valid = 1; in_op = 4'(op); in_width = 2'(w);
    in_dst = d; in_src = s; in_cnt = c;
    out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
    br_cond = 2'($urandom);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      br_cond = 2'($urandom);
      #1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R3 R4: byte add wraps to zero with carry, upper bytes kept
    send(0, 0, 32'hAABBCCFF, 32'h00000001, 0);
    send(0, 1, 32'h1234FFFF, 32'h00000001, 0);
    send(0, 2, 32'hFFFFFFFF, 32'h00000002, 0);
    send(0, 3, 32'h7FFFFFFF, 32'h00000001, 0);
    // R4 borrow, logic clears carry
    send(1, 0, 32'h11111103, 32'h00000005, 0);
    send(2, 1, 32'hDEADBEEF, 32'h0000F0F0, 0);
    send(1, 1, 32'h00000005, 32'h00000003, 0);
    send(3, 0, 32'h00000081, 32'h00000002, 0);
    send(4, 2, 32'hFFFF0000, 32'h0F0F0F0F, 0);
    // R5: carry set then inc/dec; clear then inc wrap
    send(1, 0, 0, 1, 0);
    send(5, 1, 32'h5555FFFF, 0, 0);
    send(6, 0, 32'h00000000, 0, 0);
    send(0, 0, 1, 1, 0);
    send(5, 0, 32'h000000FF, 0, 0);
    // R6 R8: compare equal, below, above
    send(10, 2, 32'h00001234, 32'h00001234, 0);
    send(10, 0, 32'hFF000010, 32'h00000020, 0);
    send(10, 1, 32'h00009000, 32'h00000001, 0);
    // R7: zero count keeps flags, counts at/over width, upper count bits ignored
    send(1, 0, 0, 1, 0);
    send(7, 0, 32'h000000C3, 0, 32'hFFFFFF00);
    send(8, 1, 32'h0000ABCD, 0, 32'h00000000);
    send(7, 0, 32'h00000081, 0, 32'h12345601);
    send(7, 0, 32'h00000081, 0, 32'h00000008);
    send(8, 0, 32'h00000080, 0, 32'h00000008);
    send(8, 1, 32'h0000FFFF, 0, 32'h00000011);
    send(9, 0, 32'hAAAAAA80, 0, 32'h00000003);
    send(9, 1, 32'h00008001, 0, 32'h000000FF);
    send(9, 2, 32'h40000000, 0, 32'h00000020);
    send(7, 2, 32'h80000001, 0, 32'h0000001F);
    // R1: reserved codes
    send(12, 0, 32'h12345678, 32'h1, 0);
    // R9: random traffic under back-pressure
    bp = 1;
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 11;
      send(op, $urandom % 4, $urandom, ($urandom % 4 == 0) ? 32'($urandom % 3) : $urandom,
           ($urandom % 2) ? 32'($urandom % 40) : $urandom);
      if ($urandom % 5 == 0) begin
        in_valid = 0;
        @(negedge clk);
      end
    end
    in_valid = 0;
    bp = 0;
    out_ready = 1;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule